// File: doc/BRIEF.md
# Differential QPSK Decoder with Frame Synchronizer

This block sits behind a QPSK receiver's symbol decision stage. Each strobed symbol arrives as two sign bits, one for the in-phase and one for the quadrature component. The block maps each symbol to one of four quadrants. The phase step from the previous symbol's quadrant to the current one gives a pair of bits. Because only the step carries information, a constant rotation of the whole constellation by a multiple of 90 degrees leaves the decoded bits unchanged.

The decoded bits are scanned one at a time for a 16-bit alternating synchronization word. Once the word is found, the next 3206 bits form the payload. The payload is assembled into 458 characters of 7 bits each, most significant bit first. After the last payload bit the block searches for the synchronization word again, starting with the very next bit.

Top module: `dqpsk_frame_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `bits_vld`, `char_vld` and `sync_found` are low. The first strobed symbol after reset only loads the previous-quadrant register, so the cycle after it shows `bits_vld` low.
- R2: The quadrant index depends on the sign flags (`sym_i_neg`, `sym_q_neg`) as follows: (0,0) gives 0, (1,0) gives 1, (1,1) gives 2 and (0,1) gives 3. Quadrant indices increase counter-clockwise.
- R3: The phase step is (current quadrant − previous quadrant) mod 4. A step of 0 gives bits 00, a step of 1 (+90°) gives 01, a step of 2 (180°) gives 11 and a step of 3 (−90°) gives 10. `bits[1]` is the earlier bit of the pair in the serial stream.
- R4: `bits_vld` is high exactly in the cycle after each strobe, except after the first strobe following reset. A cycle without a strobe produces no bits, no character and no change of `sync_found`.
- R5: The synchronization word is found when the last 16 serial bits equal 0x5555, where the earliest bit is the MSB and is 0. At least 16 bits must have been searched since reset or since the last payload ended. `sync_found` goes high one cycle after the `bits_vld` cycle that completes the word.
- R6: A synchronization word with any single bit wrong is not detected.
- R7: The 3206 bits after the synchronization word are packed into 458 characters of 7 bits, the first bit being the MSB. `char_vld` pulses one cycle after the `bits_vld` cycle that supplies the seventh bit of a character.
- R8: `sync_found` falls one cycle after the `bits_vld` cycle holding the 3206th payload bit. Search restarts with the next serial bit, even if that is the second bit of the same pair.
- R9: If the synchronization word completes on the first bit of a pair, the second bit of that pair is payload bit 0.
- R10: While `sync_found` is high, a synchronization pattern inside the payload neither restarts nor shortens the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | Symbol decision strobe |
| sym_i_neg | input | 1 | In-phase decision is negative |
| sym_q_neg | input | 1 | Quadrature decision is negative |
| bits_vld | output | 1 | Decoded bit pair valid |
| bits | output | 2 | Decoded pair, bit 1 first in time |
| sync_found | output | 1 | High while payload bits are being taken |
| char_vld | output | 1 | Character valid pulse |
| char_data | output | 7 | Assembled character, MSB received first |

## Verification
The hardest cases to reach from the ports are the two places where a frame edge falls between the two bits of one symbol. One is a synchronization word that completes on the first bit of a pair. The other is a payload that ends on the first bit of a pair, so that the second bit must restart the search. The bench builds its symbol stream from an intended bit sequence with an odd-length gap before the second frame. This places both frame edges in the middle of a symbol. A third frame follows immediately after the second payload, so search must resume on that very bit. The payload starts with characters that continue the alternating pattern to show that a false synchronization word inside the data has no effect.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  localparam int SYM_BITS = 2;

  // quadrant index from sign flags, counter-clockwise numbering
  function automatic logic [1:0] quad_of(input logic i_neg, input logic q_neg);
    return {q_neg, i_neg ^ q_neg};
  endfunction

  // phase step (mod 4) to bit pair: 0->00, 1->01, 2->11, 3->10
  function automatic logic [1:0] pair_of_step(input logic [1:0] step);
    return {step[1], step[1] ^ step[0]};
  endfunction
endpackage

// File: rtl/dq_diff_decoder.sv
module dq_diff_decoder
  import dqpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb,
  input  logic       sym_i_neg,
  input  logic       sym_q_neg,
  output logic       pair_vld,
  output logic [1:0] pair
);
  logic       have_prev;
  logic [1:0] prev_quad;
  logic [1:0] cur_quad;
  logic [1:0] step;

  assign cur_quad = quad_of(sym_i_neg, sym_q_neg);
  assign step     = cur_quad - prev_quad;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_quad <= '0;
      pair_vld  <= 1'b0;
      pair      <= '0;
    end else begin
      pair_vld <= 1'b0;
      if (sym_stb) begin
        have_prev <= 1'b1;
        prev_quad <= cur_quad;
        if (have_prev) begin
          pair_vld <= 1'b1;
          pair     <= pair_of_step(step);
        end
      end
    end
  end
endmodule

// File: rtl/dq_frame_ctrl.sv
module dq_frame_ctrl
  import dqpsk_pkg::*;
#(
  parameter int              SYNC_LEN     = 16,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 16'h5555,
  parameter int              PAYLOAD_BITS = 3206
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pair_vld,
  input  logic [SYM_BITS-1:0] pair,
  output logic [SYM_BITS-1:0] pay_mask,
  output logic                in_payload
);
  localparam int CNT_W  = $clog2(PAYLOAD_BITS);
  localparam int FILL_W = $clog2(SYNC_LEN + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(PAYLOAD_BITS - 1);
  localparam logic [FILL_W-1:0] FULL     = FILL_W'(SYNC_LEN);

  logic [SYNC_LEN-1:0] sh_q, sh_n;
  logic [FILL_W-1:0]   fill_q, fill_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                pay_n;

  // serial walk over the pair, earlier bit (MSB) first
  always_comb begin
    sh_n     = sh_q;
    fill_n   = fill_q;
    cnt_n    = cnt_q;
    pay_n    = in_payload;
    pay_mask = '0;
    if (pair_vld) begin
      for (int b = SYM_BITS - 1; b >= 0; b--) begin
        if (pay_n) begin
          pay_mask[b] = 1'b1;
          if (cnt_n == LAST_BIT) begin
            cnt_n  = '0;
            pay_n  = 1'b0;
            fill_n = '0;
          end else begin
            cnt_n = cnt_n + 1'b1;
          end
        end else begin
          sh_n = {sh_n[SYNC_LEN-2:0], pair[b]};
          if (fill_n != FULL) fill_n = fill_n + 1'b1;
          if (fill_n == FULL && sh_n == SYNC_WORD) begin
            pay_n = 1'b1;
            cnt_n = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      fill_q     <= '0;
      cnt_q      <= '0;
      in_payload <= 1'b0;
    end else begin
      sh_q       <= sh_n;
      fill_q     <= fill_n;
      cnt_q      <= cnt_n;
      in_payload <= pay_n;
    end
  end
endmodule

// File: rtl/dq_char_packer.sv
module dq_char_packer
  import dqpsk_pkg::*;
#(
  parameter int CHAR_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SYM_BITS-1:0]  pay_mask,
  input  logic [SYM_BITS-1:0]  pair,
  output logic                 char_vld,
  output logic [CHAR_BITS-1:0] char_data
);
  localparam int CW = $clog2(CHAR_BITS);
  localparam logic [CW-1:0] LAST = CW'(CHAR_BITS - 1);

  logic [CHAR_BITS-1:0] acc_q, acc_n, out_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic                 done_n;

  always_comb begin
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    out_n  = char_data;
    done_n = 1'b0;
    for (int b = SYM_BITS - 1; b >= 0; b--) begin
      if (pay_mask[b]) begin
        acc_n = {acc_n[CHAR_BITS-2:0], pair[b]};
        if (cnt_n == LAST) begin
          cnt_n  = '0;
          done_n = 1'b1;
          out_n  = acc_n;
        end else begin
          cnt_n = cnt_n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      char_vld  <= 1'b0;
      char_data <= '0;
    end else begin
      acc_q     <= acc_n;
      cnt_q     <= cnt_n;
      char_vld  <= done_n;
      char_data <= out_n;
    end
  end
endmodule

// File: rtl/dqpsk_frame_decoder.sv
module dqpsk_frame_decoder
  import dqpsk_pkg::*;
#(
  parameter int SYNC_LEN                  = 16,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 16'h5555,
  parameter int PAYLOAD_BITS              = 3206,
  parameter int CHAR_BITS                 = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sym_stb,
  input  logic                 sym_i_neg,
  input  logic                 sym_q_neg,
  output logic                 bits_vld,
  output logic [1:0]           bits,
  output logic                 sync_found,
  output logic                 char_vld,
  output logic [CHAR_BITS-1:0] char_data
);
  logic [SYM_BITS-1:0] pay_mask;

  dq_diff_decoder u_diff (
    .clk(clk), .rst(rst), .sym_stb(sym_stb),
    .sym_i_neg(sym_i_neg), .sym_q_neg(sym_q_neg),
    .pair_vld(bits_vld), .pair(bits)
  );

  dq_frame_ctrl #(
    .SYNC_LEN(SYNC_LEN), .SYNC_WORD(SYNC_WORD), .PAYLOAD_BITS(PAYLOAD_BITS)
  ) u_frame (
    .clk(clk), .rst(rst), .pair_vld(bits_vld), .pair(bits),
    .pay_mask(pay_mask), .in_payload(sync_found)
  );

  dq_char_packer #(.CHAR_BITS(CHAR_BITS)) u_pack (
    .clk(clk), .rst(rst), .pay_mask(pay_mask), .pair(bits),
    .char_vld(char_vld), .char_data(char_data)
  );
endmodule

// File: rtl/dqpsk_frame_decoder_chk.sv
module dqpsk_frame_decoder_chk #(
  parameter int CHAR_BITS = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sym_stb,
  input logic                 bits_vld,
  input logic                 sync_found,
  input logic                 char_vld,
  input logic [CHAR_BITS-1:0] char_data
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (sym_stb) seen <= 1'b1;
  end

  p_first_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (sym_stb && !seen) |=> !bits_vld);

  p_vld_follows_stb_r4: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> !bits_vld);

  p_quiet_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    !bits_vld |=> (!char_vld && $stable(sync_found)));

  p_sync_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_found) |-> $past(bits_vld));

  p_sync_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_found) |-> $past(bits_vld));

  p_char_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    char_vld |-> ($past(sync_found) && $past(bits_vld)));

  p_char_known_r7: assert property (@(posedge clk) disable iff (rst)
    char_vld |-> !$isunknown(char_data));
endmodule

bind dqpsk_frame_decoder dqpsk_frame_decoder_chk #(.CHAR_BITS(CHAR_BITS)) u_chk (
  .clk(clk), .rst(rst), .sym_stb(sym_stb), .bits_vld(bits_vld),
  .sync_found(sync_found), .char_vld(char_vld), .char_data(char_data)
);

// File: tb/dqpsk_frame_decoder_test.sv
`timescale 1ns/1ps
module dqpsk_frame_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_stb = 1'b0, sym_i_neg = 1'b0, sym_q_neg = 1'b0;
  logic bits_vld, sync_found, char_vld;
  logic [1:0] bits;
  logic [6:0] char_data;

  always #5 clk = ~clk;

  dqpsk_frame_decoder uut (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .sym_i_neg(sym_i_neg),
    .sym_q_neg(sym_q_neg), .bits_vld(bits_vld), .bits(bits),
    .sync_found(sync_found), .char_vld(char_vld), .char_data(char_data)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit stream[$];
  int exp_chars[$];
  int got_chars[$];
  int rises = 0, falls = 0;
  logic prev_sf = 1'b0;
  int tx_q = 0, gap_n = 0;

  // behavioural reference model
  bit m_have; int m_prev; bit m_bv; int m_bits;
  bit [15:0] m_sh; int m_fill; int m_cnt; bit m_pay;
  int m_acc, m_ccnt; bit m_cv; int m_cd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_have = 0; m_prev = 0; m_bv = 0; m_bits = 0; m_sh = 0; m_fill = 0;
      m_cnt = 0; m_pay = 0; m_acc = 0; m_ccnt = 0; m_cv = 0; m_cd = 0;
    end else begin
      m_cv = 0;
      if (m_bv) begin
        for (int b = 1; b >= 0; b--) begin
          bit bt;
          bt = m_bits[b];
          if (m_pay) begin
            m_acc = ((m_acc << 1) | bt) & 127;
            m_ccnt++;
            if (m_ccnt == 7) begin m_cv = 1; m_cd = m_acc; m_ccnt = 0; end
            m_cnt++;
            if (m_cnt == 3206) begin m_pay = 0; m_cnt = 0; m_fill = 0; end
          end else begin
            m_sh = {m_sh[14:0], bt};
            if (m_fill < 16) m_fill++;
            if (m_fill == 16 && m_sh == 16'h5555) m_pay = 1;
          end
        end
      end
      m_bv = 0;
      if (sym_stb) begin
        int q, d;
        q = sym_q_neg ? (sym_i_neg ? 2 : 3) : (sym_i_neg ? 1 : 0);
        if (m_have) begin
          d = (q - m_prev) & 3;
          m_bits = (d == 0) ? 0 : (d == 1) ? 1 : (d == 2) ? 3 : 2;
          m_bv = 1;
        end
        m_have = 1; m_prev = q;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // per-cycle comparison and output collection
  always @(negedge clk) begin
    if (!rst) begin
      chk(bits_vld == m_bv && (!m_bv || bits == 2'(m_bits)), "R3/R4 bits",
          {bits_vld, bits}, {m_bv, 2'(m_bits)});
      chk(sync_found == m_pay, "R5/R8 sync_found", sync_found, m_pay);
      chk(char_vld == m_cv && (!m_cv || char_data == 7'(m_cd)), "R7 char",
          {char_vld, char_data}, {m_cv, 7'(m_cd)});
      if (char_vld) got_chars.push_back(int'(char_data));
      if (sync_found && !prev_sf) rises++;
      if (!sync_found && prev_sf) falls++;
      prev_sf = sync_found;
    end
  end

  task automatic drive(input bit in_, input bit qn);
    sym_stb = 1; sym_i_neg = in_; sym_q_neg = qn;
    @(negedge clk);
    sym_stb = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pairs(input int n);
    for (int k = 0; k < n; k++) begin
      bit b1, b0;
      int d;
      b1 = stream.pop_front(); b0 = stream.pop_front();
      d = b1 ? (b0 ? 2 : 3) : (b0 ? 1 : 0);
      tx_q = (tx_q + d) & 3;
      drive(tx_q == 1 || tx_q == 2, tx_q >= 2);
      gap_n++;
      idle((gap_n % 5 == 0) ? 0 : (gap_n % 7 == 0) ? 2 : 1);
    end
  endtask

  task automatic push_bits(input int val, input int width);
    for (int i = width - 1; i >= 0; i--) stream.push_back(bit'((val >> i) & 1));
  endtask

  task automatic push_payload();
    for (int k = 0; k < 458; k++) begin
      int c;
      c = (k == 0 || k == 2) ? 'h2A : (k == 1) ? 'h55 : (k * 37 + 11) % 128;
      exp_chars.push_back(c);
      push_bits(c, 7);
    end
  endtask

  initial begin
    int mism;
    idle(3);
    chk(!bits_vld && !char_vld && !sync_found, "R1 reset", {bits_vld, char_vld, sync_found}, 0);
    rst = 0;
    idle(1);
    chk(!bits_vld && !char_vld && !sync_found, "R1 after reset", {bits_vld, char_vld, sync_found}, 0);
    // directed quadrant walk 0 -> 1 -> 2 -> 0 -> 3
    drive(0, 0);
    chk(!bits_vld, "R1 first symbol silent", bits_vld, 0);
    idle(1);
    drive(1, 0);
    chk(bits_vld && bits == 2'b01, "R2 quadrant (1,0)=1", {bits_vld, bits}, 3'b101);
    drive(1, 1);
    chk(bits_vld && bits == 2'b01, "R3 +90 gives 01", {bits_vld, bits}, 3'b101);
    drive(0, 0);
    chk(bits_vld && bits == 2'b11, "R3 180 gives 11", {bits_vld, bits}, 3'b111);
    drive(0, 1);
    chk(bits_vld && bits == 2'b10, "R3 -90 gives 10", {bits_vld, bits}, 3'b110);
    idle(1);
    chk(!bits_vld, "R4 no strobe no bits", bits_vld, 0);
    tx_q = 3;

    // preamble with a corrupted sync word
    push_bits('hFF, 8); push_bits('h5575, 16); push_bits('hFF, 8);
    // frame 1: aligned
    push_bits('h5555, 16); push_payload();
    // frame 2: one extra bit puts both frame edges mid-pair
    push_bits(1, 1); push_bits('h5555, 16); push_payload();
    // frame 3 starts on the very next bit, one pad bit
    push_bits('h5555, 16); push_bits(0, 1);

    send_pairs(16);
    idle(2);
    chk(!sync_found, "R6 corrupted word ignored", sync_found, 0);
    send_pairs(8 + 1611);
    idle(2);
    chk(sync_found == 0 && rises == 1 && falls == 1, "R8 frame 1 closed",
        {sync_found, 4'(rises), 4'(falls)}, 9'h011);
    send_pairs(stream.size() / 2);
    idle(3);

    chk(got_chars.size() == 916, "R7 character count", got_chars.size(), 916);
    mism = 0;
    for (int k = 0; k < 916 && k < got_chars.size(); k++)
      if (got_chars[k] != exp_chars[k]) mism++;
    chk(mism == 0, "R7/R10 character values", mism, 0);
    if (got_chars.size() > 458)
      chk(got_chars[458] == 'h2A && got_chars[459] == 'h55, "R9 mid-pair sync alignment",
          got_chars[458], 'h2A);
    chk(rises == 3, "R5/R10 sync detections", rises, 3);
    chk(falls == 2, "R8 payload ends", falls, 2);
    chk(sync_found, "R8 search resumes at next bit", sync_found, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule